// File: doc/BRIEF.md
# Addressed Circulating Serial Memory

This block is a bit store made of a bank of equal-length circulating shift registers. Every register advances by one place at the same moment, and its last bit wraps back to its first place, so the contents are kept without any external refresh. The only bit of a register that can be reached is the one currently sitting at its access position. A register address picks which register's access bit is read or written. Changing the address between shifts reaches any register at random. Inside one register the bits are reached only in sequence, as the shifts carry them past the access position.

A shift is not a single edge. An internal sequencer steps through eight intervals and produces four overlapping phase clocks. The block reports busy for the whole sequence. Reads and writes are accepted only while the block is idle. The data output behaves as an open-drain line: it pulls low when the selected bit is zero and is otherwise released, so several such outputs can be wired together. A shared position counter reports which bit index of every register is at the access position.

Top module: `circ_serial_mem`

## Requirements
- R1: After reset, `busy` is 0, `pos` is 0, `phase_clk` is 0 and `rd_pull_low` is 0.
- R2: When `shift_req` is sampled high at a clock edge while idle, `busy` is 1 from that edge for exactly 8 cycles and then returns to 0.
- R3: During busy interval k (0 to 7, counted from the first busy cycle), phase bit p (0 to 3) of `phase_clk` is 1 exactly when k equals 2p, 2p+1 or (2p+7) mod 8; while idle `phase_clk` is 0.
- R4: `shift_req` sampled while busy is ignored: the sequence still lasts 8 cycles and no second shift follows.
- R5: Each completed shift moves every register forward by one bit with wrap-around, and `pos` increments by one, wrapping from 255 to 0 in the same cycle that `busy` falls.
- R6: `wr_en` sampled high while idle replaces the access-position bit of the register selected by `addr` with `din`; other registers are unchanged.
- R7: While busy, `wr_en` has no effect on any stored bit and `rd_pull_low` stays 0.
- R8: `rd_pull_low` is 1 in the same cycle, with no clock edge needed, exactly when `rd_en` is 1, the block is idle and the access-position bit of register `addr` is 0. A value of 1 means the line is pulled low and 0 means it is released.
- R9: With `addr` held, successive shifts present a register's bits one after another. A bit written at index i is read back when `pos` again equals i, 256 shifts later.
- R10: Between shifts, changing `addr` alone reads the access bit of any of the 64 registers in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 6 | Register select |
| din | input | 1 | Bit to write |
| wr_en | input | 1 | Write the access bit of the selected register |
| rd_en | input | 1 | Enable the open-drain read output |
| shift_req | input | 1 | Start one shift sequence |
| busy | output | 1 | Shift sequence in progress |
| phase_clk | output | 4 | Four phase clocks of the shift sequence |
| pos | output | 8 | Bit index at the access position |
| rd_pull_low | output | 1 | 1 = output line pulled low (bit is 0), 0 = released |

## Verification
On every cycle, the embedded assertions check several properties. They check that the sequencer steps through its intervals one per cycle once started and that the phase clocks show one or two active phases only while busy. They check that the position changes only on a completed shift, that an accepted write lands in the addressed register, that the access bit wraps to the far end on a shift, and that the read line is never pulled while busy. Only the directed scenarios can show the end-to-end serial behaviour: a bit comes back after a full lap of 256 shifts, random access works across all 64 registers, and a write attempted during a shift is absent a whole lap later.

// File: rtl/circ_mem_pkg.sv
package circ_mem_pkg;

  // Phase p is active in interval 2p, 2p+1 and the interval just before 2p,
  // giving overlapping four-phase clocks over 2*np intervals.
  function automatic logic phase_active(input int p, input int k, input int np);
    int n;
    n = 2 * np;
    return (k == 2 * p) || (k == 2 * p + 1) || (k == (2 * p + n - 1) % n);
  endfunction

endpackage

// File: rtl/cm_phase_seq.sv
module cm_phase_seq #(
  parameter int NUM_PHASES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_req,
  output logic                  busy,
  output logic [NUM_PHASES-1:0] phases,
  output logic                  step
);
  import circ_mem_pkg::*;

  localparam int NUM_IVL = 2 * NUM_PHASES;
  localparam int IVL_W   = $clog2(NUM_IVL);
  localparam logic [IVL_W-1:0] LAST_IVL = IVL_W'(NUM_IVL - 1);

  logic             busy_q, busy_d;
  logic [IVL_W-1:0] ivl_q, ivl_d;

  always_comb begin
    busy_d = busy_q;
    ivl_d  = ivl_q;
    step   = 1'b0;
    if (!busy_q) begin
      if (start_req) begin
        busy_d = 1'b1;
        ivl_d  = '0;
      end
    end else if (ivl_q == LAST_IVL) begin
      busy_d = 1'b0;
      ivl_d  = '0;
      step   = 1'b1;
    end else begin
      ivl_d = ivl_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ivl_q  <= '0;
    end else begin
      busy_q <= busy_d;
      ivl_q  <= ivl_d;
    end
  end

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
    assign phases[p] = busy_q && phase_active(p, int'(ivl_q), NUM_PHASES);
  end

  assign busy = busy_q;

  assert_seq_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> ivl_q == '0);
  assert_seq_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ivl_q != LAST_IVL) |=> busy_q);
  assert_seq_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && ivl_q != LAST_IVL) |=> ivl_q == $past(ivl_q) + 1'b1);
  assert_phase_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ($countones(phases) == 1 || $countones(phases) == 2));
  assert_phase_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> phases == '0);

endmodule

// File: rtl/cm_pos_counter.sv
module cm_pos_counter #(
  parameter int REG_BITS = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step,
  output logic [$clog2(REG_BITS)-1:0] pos
);
  localparam int POS_W = $clog2(REG_BITS);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(REG_BITS - 1);

  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (step) begin
      pos_d = (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

  assert_pos_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> pos_q != $past(pos_q));
  assert_pos_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos_q));

endmodule

// File: rtl/cm_ring_array.sv
module cm_ring_array #(
  parameter int N_REGS   = 64,
  parameter int REG_BITS = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      step,
  input  logic                      wr_accept,
  input  logic [$clog2(N_REGS)-1:0] addr,
  input  logic                      din,
  output logic                      acc_bit
);
  localparam int ADDR_W = $clog2(N_REGS);

  logic [REG_BITS-1:0] ring [N_REGS];

  // Storage is not reset: contents are defined only by writes.
  always_ff @(posedge clk) begin
    if (step) begin
      for (int r = 0; r < N_REGS; r++) begin
        ring[r] <= {ring[r][0], ring[r][REG_BITS-1:1]};
      end
    end else if (wr_accept) begin
      ring[addr][0] <= din;
    end
  end

  assign acc_bit = ring[addr][0];

  assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !step) |=> ring[$past(addr)][0] == $past(din));
  assert_wrap_around_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> ring[$past(addr)][REG_BITS-1] == $past(acc_bit));
  assert_no_write_on_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && wr_accept));

endmodule

// File: rtl/circ_serial_mem.sv
module circ_serial_mem #(
  parameter int N_REGS     = 64,
  parameter int REG_BITS   = 256,
  parameter int NUM_PHASES = 4,
  localparam int ADDR_W    = $clog2(N_REGS),
  localparam int POS_W     = $clog2(REG_BITS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  din,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic                  shift_req,
  output logic                  busy,
  output logic [NUM_PHASES-1:0] phase_clk,
  output logic [POS_W-1:0]      pos,
  output logic                  rd_pull_low
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       step;
  logic       acc_bit;
  logic       wr_accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cm_phase_seq #(.NUM_PHASES(NUM_PHASES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_req (shift_req),
    .busy      (busy),
    .phases    (phase_clk),
    .step      (step)
  );

  cm_pos_counter #(.REG_BITS(REG_BITS)) u_pos (
    .clk   (clk),
    .rst_n (rst_int_n),
    .step  (step),
    .pos   (pos)
  );

  assign wr_accept = wr_en && !busy && rst_int_n;

  cm_ring_array #(.N_REGS(N_REGS), .REG_BITS(REG_BITS)) u_ring (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .step      (step),
    .wr_accept (wr_accept),
    .addr      (addr),
    .din       (din),
    .acc_bit   (acc_bit)
  );

  // Open-drain style: pull only when a zero is read while idle.
  assign rd_pull_low = rd_en && !busy && rst_int_n && !acc_bit;

  assert_read_idle_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_pull_low |-> !busy);
  assert_read_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rd_en |-> !rd_pull_low);

endmodule

// File: tb/circ_serial_mem_tb.sv
module circ_serial_mem_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] addr;
  logic       din, wr_en, rd_en, shift_req;
  logic       busy;
  logic [3:0] phase_clk;
  logic [7:0] pos;
  logic       rd_pull_low;

  int checks = 0;
  int errors = 0;
  bit mdl [64][256];
  int pos_m = 0;

  always #10 clk = ~clk;

  circ_serial_mem u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .wr_en(wr_en),
    .rd_en(rd_en), .shift_req(shift_req), .busy(busy), .phase_clk(phase_clk),
    .pos(pos), .rd_pull_low(rd_pull_low)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_phase(input int k);
    logic [3:0] v;
    for (int p = 0; p < 4; p++)
      v[p] = (k == 2*p) || (k == 2*p+1) || (k == (2*p+7) % 8);
    return v;
  endfunction

  function automatic bit pat(input int r, input int i);
    return bit'(((i * 7) ^ (i >> 3) ^ (r * 5)) & 1);
  endfunction

  // Shift; optionally re-request at interval 3 (R4) and check phases (R3).
  task automatic do_shift(input bit recheck_phases, input bit extra_req);
    int n = 0;
    @(negedge clk); shift_req = 1'b1;
    @(negedge clk); shift_req = 1'b0;
    while (busy && n < 20) begin
      if (recheck_phases)
        check(phase_clk == exp_phase(n), "R3 phase", int'(phase_clk), int'(exp_phase(n)));
      if (extra_req) shift_req = (n == 3);
      n++;
      @(negedge clk);
    end
    shift_req = 1'b0;
    check(n == 8, "R2 busy length", n, 8);
    pos_m = (pos_m + 1) % 256;
    check(pos == 8'(pos_m), "R5 position", int'(pos), pos_m);
  endtask

  task automatic write_bit(input int r, input bit v);
    @(negedge clk); addr = 6'(r); din = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    mdl[r][pos_m] = v;
  endtask

  task automatic read_check(input int r, input string req);
    @(negedge clk); addr = 6'(r); rd_en = 1'b1;
    #1 check(rd_pull_low == !mdl[r][pos_m], req, int'(rd_pull_low), int'(!mdl[r][pos_m]));
    rd_en = 1'b0;
    #1 check(rd_pull_low == 1'b0, "R8 released without rd_en", int'(rd_pull_low), 0);
  endtask

  task automatic t_reset;
    check(busy == 1'b0, "R1 busy", int'(busy), 0);
    check(pos == 8'd0, "R1 pos", int'(pos), 0);
    check(phase_clk == 4'd0, "R1 phase", int'(phase_clk), 0);
    check(rd_pull_low == 1'b0, "R1 read line", int'(rd_pull_low), 0);
  endtask

  task automatic t_phases;
    do_shift(1'b1, 1'b0);
    repeat (2) @(negedge clk);
    check(phase_clk == 4'd0, "R3 idle phases", int'(phase_clk), 0);
  endtask

  // R9: fill register 5 over one lap, read it back over the next lap.
  task automatic t_serial_lap;
    for (int i = 0; i < 256; i++) begin
      write_bit(5, pat(5, pos_m));
      do_shift(1'b0, 1'b0);
    end
    for (int i = 0; i < 256; i++) begin
      read_check(5, "R9 lap readback");
      do_shift(1'b0, 1'b0);
    end
  endtask

  task automatic t_req_while_busy;
    int p0 = pos_m;
    do_shift(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R4 no second shift", int'(busy), 0);
    check(pos == 8'((p0 + 1) % 256), "R4 single step", int'(pos), (p0 + 1) % 256);
  endtask

  // R7: write and read attempts during a shift have no effect.
  task automatic t_busy_access;
    int p0 = pos_m;
    bit orig = mdl[5][p0];
    int n = 0;
    @(negedge clk); shift_req = 1'b1;
    @(negedge clk); shift_req = 1'b0;
    addr = 6'd5; din = !orig; wr_en = 1'b1; rd_en = 1'b1;
    while (busy && n < 20) begin
      #1 check(rd_pull_low == 1'b0, "R7 read line while busy", int'(rd_pull_low), 0);
      if (n == 6) wr_en = 1'b0;
      n++;
      @(negedge clk);
    end
    wr_en = 1'b0; rd_en = 1'b0;
    pos_m = (pos_m + 1) % 256;
    for (int i = 0; i < 255; i++) do_shift(1'b0, 1'b0);
    check(pos == 8'(p0), "R7 back at position", int'(pos), p0);
    read_check(5, "R7 bit unchanged by busy write");
  endtask

  // R6/R10: write every register, read back in scattered order.
  task automatic t_random_access;
    for (int r = 0; r < 64; r++) write_bit(r, pat(r, pos_m + 1));
    for (int i = 0; i < 64; i++) read_check((i * 37) % 64, "R10 random access");
    write_bit(9, !mdl[9][pos_m]);
    read_check(9, "R6 overwrite");
    read_check(8, "R6 neighbour unchanged");
    read_check(10, "R6 neighbour unchanged");
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; din = 1'b0; wr_en = 1'b0; rd_en = 1'b0; shift_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_phases();
    t_serial_lap();
    t_req_while_busy();
    t_busy_access();
    t_random_access();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule